// File: doc/BRIEF.md
# Per-Core Event Timer with Indexed Control Registers

This block is the private timer of a single processor core. The core does not reach it through memory. It selects a small control-register index and either writes a value or reads one back. The timer has two independent functions. The first is a free-running count that advances on every clock and never stops. The second is a one-shot countdown that the core arms with a tick delta. When that countdown expires, it raises a status flag and, through the enable bit, a private interrupt line.

The countdown is controlled by a three-state machine with the states IDLE, RUN and HOLD:
- IDLE means nothing is loaded, or the last countdown has expired.
- RUN means the countdown is decrementing.
- HOLD means a countdown is loaded but paused because the enable bit is clear.

The transitions are:
- **arm**: IDLE or HOLD to RUN, on a nonzero load while enabled.
- **park**: IDLE to HOLD, on a nonzero load while disabled.
- **pause**: RUN to HOLD, when the enable bit is clear.
- **resume**: HOLD to RUN, when the enable bit is set.
- **expire**: RUN to IDLE, when the last tick elapses.
- **cancel**: RUN or HOLD to IDLE, on a load of zero.
- **restart**: RUN to RUN, on a nonzero load while enabled.

Software uses the timer for one-shot events as follows. It clears the status flag in the interrupt handler, writes the next delta to arm the next event, and clears the enable bit to shut the timer down.

Top module: `core_evt_timer`

## Requirements
- R1: After reset, control bit 0 reads 0, status bit 0 reads 0, the load index reads 0, `irq` is 0, and the count index reads the parameter `COUNT_INIT`.
- R2: Index 3 returns a 32-bit count that increases by one on every clock edge, wraps from 0xFFFFFFFF to 0, and is unaffected by writes.
- R3: With control bit 0 set, writing a nonzero delta D to index 6 sets status bit 0 exactly D clock edges after the write edge. Reads of index 6 return the ticks still remaining.
- R4: After expiry, the remaining count stays 0 and no further event occurs until the next load.
- R5: Writing index 1 with bit 0 = 0 clears status bit 0. Writing it with bit 0 = 1 has no effect. An expiry in the same cycle as a clear wins.
- R6: Control index 0, bit 0 = 0, pauses the countdown and holds the remaining value. Bit 0 = 1 lets it continue.
- R7: `irq` equals status bit 0 AND control bit 0.
- R8: A load written while a countdown is running restarts it from the new delta and leaves an already pending status flag set.
- R9: Deltas from 2 up to 0xFFFFFFFF are accepted unchanged. A delta of 0 arms nothing.
- R10: Indices other than 0, 1, 3 and 6 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock; one tick per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cr_sel | input | 5 | Control-register index |
| cr_wdata | input | 32 | Write data |
| cr_we | input | 1 | Write strobe for the selected index |
| cr_rdata | output | 32 | Read data of the selected index (combinational) |
| irq | output | 1 | Private timer interrupt |

## Verification
The bench measures the expiry edge exactly. A design that fires one tick early or late, or that decrements while paused, misses the sampled cycle. It reloads while a flag is pending, which catches a design that clears status on load. It writes a 1 to status and writes unimplemented indices, which exposes decode that is too loose. It lets the count run through its wrap and arms the smallest, the largest and a zero delta. An off-by-one at the boundaries, or a countdown that starts on zero, would show up as a wrong remaining value or a spurious event.

// File: rtl/ptim_pkg.sv
package ptim_pkg;
    localparam int SEL_W = 5;
    localparam logic [SEL_W-1:0] SEL_CTRL  = 5'd0;
    localparam logic [SEL_W-1:0] SEL_STAT  = 5'd1;
    localparam logic [SEL_W-1:0] SEL_COUNT = 5'd3;
    localparam logic [SEL_W-1:0] SEL_LOAD  = 5'd6;

    typedef enum logic [1:0] {
        CD_IDLE = 2'd0,
        CD_RUN  = 2'd1,
        CD_HOLD = 2'd2
    } cd_state_t;
endpackage

// File: rtl/ptim_freerun.sv
module ptim_freerun #(
    parameter int               CNT_W = 32,
    parameter logic [CNT_W-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= INIT;
        else        count_q <= count_q + STEP;
    end

    always_comb count_o = count_q;

    // R2: advances by one every edge, wrapping naturally
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count_q == $past(count_q) + STEP);
endmodule

// File: rtl/ptim_countdown.sv
module ptim_countdown
    import ptim_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             load_we_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             clr_we_i,
    output logic [CNT_W-1:0] remain_o,
    output logic             status_o
);
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO = '0;

    cd_state_t        state_q, state_d;
    logic [CNT_W-1:0] remain_q;
    logic             status_q;
    logic             dec, expire, load_zero;

    always_comb begin
        load_zero = (load_val_i == ZERO);
        dec       = (state_q == CD_RUN) && en_i && !load_we_i;
        expire    = dec && (remain_q == ONE);
        state_d   = state_q;
        unique case (state_q)
            CD_IDLE: begin
                if (load_we_i && !load_zero) state_d = en_i ? CD_RUN : CD_HOLD;
            end
            CD_RUN: begin
                if (load_we_i)   state_d = load_zero ? CD_IDLE : (en_i ? CD_RUN : CD_HOLD);
                else if (!en_i)  state_d = CD_HOLD;
                else if (expire) state_d = CD_IDLE;
            end
            CD_HOLD: begin
                if (load_we_i)   state_d = load_zero ? CD_IDLE : (en_i ? CD_RUN : CD_HOLD);
                else if (en_i)   state_d = CD_RUN;
            end
            default: state_d = CD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= ZERO;
            status_q <= 1'b0;
        end else begin
            if (load_we_i) remain_q <= load_val_i;
            else if (dec)  remain_q <= remain_q - ONE;
            if (expire)        status_q <= 1'b1;
            else if (clr_we_i) status_q <= 1'b0;
        end
    end

    always_comb begin
        remain_o = remain_q;
        status_o = status_q;
    end

    // R3: a running, enabled countdown loses one tick per edge
    assert_remain_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CD_RUN && en_i && !load_we_i) |=> remain_o == $past(remain_o) - ONE);
    // R3/R4: status only rises from the last tick of a run
    assert_status_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o) |-> $past(state_q == CD_RUN && remain_o == ONE && en_i));
    // R6: disabled countdown holds its value
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_we_i) |=> $stable(remain_o));
    // R5: clear without concurrent expiry drops the flag
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && !(state_q == CD_RUN && en_i && !load_we_i && remain_o == ONE)) |=> !status_o);
    // R8: reloading never clears a pending flag
    assert_reload_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_we_i && status_o && !clr_we_i) |=> status_o);
endmodule

// File: rtl/ptim_regport.sv
module ptim_regport
    import ptim_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             we_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] remain_i,
    input  logic             status_i,
    output logic             en_o,
    output logic             load_we_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             clr_we_o,
    output logic [CNT_W-1:0] rdata_o
);
    logic ctrl_q;
    logic ctrl_we;

    always_comb begin
        ctrl_we    = we_i && (sel_i == SEL_CTRL);
        load_we_o  = we_i && (sel_i == SEL_LOAD);
        clr_we_o   = we_i && (sel_i == SEL_STAT) && !wdata_i[0];
        load_val_o = wdata_i;
        en_o       = ctrl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= 1'b0;
        else if (ctrl_we) ctrl_q <= wdata_i[0];
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel_i)
            SEL_CTRL:  rdata_o[0] = ctrl_q;
            SEL_STAT:  rdata_o[0] = status_i;
            SEL_COUNT: rdata_o    = count_i;
            SEL_LOAD:  rdata_o    = remain_i;
            default:   rdata_o    = '0;
        endcase
    end

    // R10: a write to an unimplemented index raises no strobe
    assert_unimpl_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i != SEL_CTRL && sel_i != SEL_STAT && sel_i != SEL_LOAD)
        |-> !(ctrl_we || load_we_o || clr_we_o));
    // R10: control only changes through its own index
    assert_ctrl_only_own_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && sel_i == SEL_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/core_evt_timer.sv
module core_evt_timer
    import ptim_pkg::*;
#(
    parameter int           CNT_W      = 32,
    parameter logic [31:0]  COUNT_INIT = 32'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       cr_sel,
    input  logic [31:0]      cr_wdata,
    input  logic             cr_we,
    output logic [31:0]      cr_rdata,
    output logic             irq
);
    logic [CNT_W-1:0] count, remain, load_val, rdata;
    logic             en, load_we, clr_we, status;

    ptim_freerun #(.CNT_W(CNT_W), .INIT(COUNT_INIT[CNT_W-1:0])) u_free (
        .clk(clk), .rst_n(rst_n), .count_o(count));

    ptim_countdown #(.CNT_W(CNT_W)) u_cd (
        .clk(clk), .rst_n(rst_n), .en_i(en), .load_we_i(load_we),
        .load_val_i(load_val), .clr_we_i(clr_we),
        .remain_o(remain), .status_o(status));

    ptim_regport #(.CNT_W(CNT_W)) u_rp (
        .clk(clk), .rst_n(rst_n), .sel_i(cr_sel), .wdata_i(cr_wdata[CNT_W-1:0]),
        .we_i(cr_we), .count_i(count), .remain_i(remain), .status_i(status),
        .en_o(en), .load_we_o(load_we), .load_val_o(load_val),
        .clr_we_o(clr_we), .rdata_o(rdata));

    always_comb begin
        cr_rdata = rdata;
        irq      = status & en;
    end

    // R7: the interrupt rises only with both the flag and enable present
    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (status && en));
endmodule

// File: tb/test_core_evt_timer.sv
module test_core_evt_timer;
    localparam logic [31:0] INIT = 32'hFFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cr_sel = '0;
    logic [31:0] cr_wdata = '0;
    logic        cr_we = 1'b0;
    logic [31:0] cr_rdata;
    logic        irq;
    int checks = 0;
    int failures = 0;

    core_evt_timer #(.COUNT_INIT(INIT)) i_core_evt_timer (
        .clk(clk), .rst_n(rst_n), .cr_sel(cr_sel), .cr_wdata(cr_wdata),
        .cr_we(cr_we), .cr_rdata(cr_rdata), .irq(irq));

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [4:0] sel, output logic [31:0] v);
        cr_sel = sel;
        #1;
        v = cr_rdata;
    endtask

    task automatic wr(input logic [4:0] sel, input logic [31:0] d);
        cr_sel = sel; cr_wdata = d; cr_we = 1'b1;
        @(negedge clk);
        cr_we = 1'b0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        waitn(3);
        rst_n = 1'b1;
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(1, v); chk("R1 status", v, 0);
        rd(6, v); chk("R1 load", v, 0);
        rd(3, v); chk("R1 count", v, INIT);
        chk("R1 irq", {31'd0, irq}, 0);
        waitn(20);
        rd(3, v); chk("R2 wrap", v, 32'h4);
    endtask

    task automatic t_count;
        logic [31:0] a, b;
        rd(3, a); waitn(7); rd(3, b); chk("R2 step", b, a + 7);
        rd(3, a); wr(3, 32'h0); rd(3, b); chk("R2 write ignored", b, a + 1);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        wr(0, 1); wr(6, 5);
        rd(6, v); chk("R3 remaining", v, 5);
        waitn(4); rd(1, v); chk("R3 early", v, 0);
        chk("R7 no irq early", {31'd0, irq}, 0);
        waitn(1); rd(1, v); chk("R3 expiry", v, 1);
        chk("R7 irq", {31'd0, irq}, 1);
        waitn(3); rd(6, v); chk("R4 stays zero", v, 0);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        wr(1, 1); rd(1, v); chk("R5 write one ignored", v, 1);
        wr(1, 0); rd(1, v); chk("R5 cleared", v, 0);
        chk("R5 irq low", {31'd0, irq}, 0);
        waitn(10); rd(1, v); chk("R4 no refire", v, 0);
    endtask

    task automatic t_min_mask;
        logic [31:0] v;
        wr(6, 2);
        waitn(1); rd(1, v); chk("R9 min early", v, 0);
        waitn(1); rd(1, v); chk("R9 min expiry", v, 1);
        wr(0, 0); rd(1, v); chk("R7 status kept", v, 1);
        chk("R7 masked", {31'd0, irq}, 0);
        wr(0, 1); chk("R7 unmasked", {31'd0, irq}, 1);
        wr(1, 0);
    endtask

    task automatic t_pause;
        logic [31:0] v;
        wr(6, 100); waitn(3); rd(6, v); chk("R3 countdown", v, 97);
        wr(0, 0); rd(6, v); chk("R6 paused", v, 96);
        waitn(5); rd(6, v); chk("R6 held", v, 96);
        wr(0, 1); waitn(10); rd(6, v);
        chk("R6 resumed", {31'd0, (v < 96 && v > 80)}, 1);
        wr(6, 0); rd(6, v); chk("R9 zero load", v, 0);
        waitn(5); rd(1, v); chk("R9 zero arms nothing", v, 0);
    endtask

    task automatic t_reload;
        logic [31:0] v;
        wr(6, 3); waitn(3); rd(1, v); chk("R8 first expiry", v, 1);
        wr(6, 10); rd(1, v); chk("R8 pending kept", v, 1);
        rd(6, v); chk("R8 restarted", v, 10);
        waitn(2); wr(1, 0); rd(6, v); chk("R8 running", v, 7);
        waitn(6); rd(1, v); chk("R8 not yet", v, 0);
        waitn(1); rd(1, v); chk("R8 second expiry", v, 1);
        wr(1, 0);
    endtask

    task automatic t_max_unimpl;
        logic [31:0] v;
        wr(6, 32'hFFFF_FFFF); rd(6, v); chk("R9 max", v, 32'hFFFF_FFFF);
        waitn(3); wr(0, 0); rd(6, v); chk("R9 max count", v, 32'hFFFF_FFFB);
        rd(2, v); chk("R10 read 2", v, 0);
        rd(7, v); chk("R10 read 7", v, 0);
        rd(31, v); chk("R10 read 31", v, 0);
        wr(2, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF); wr(4, 0);
        rd(0, v); chk("R10 ctrl unchanged", v, 0);
        rd(1, v); chk("R10 status unchanged", v, 0);
        rd(6, v); chk("R10 load unchanged", v, 32'hFFFF_FFFB);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_count;
        t_oneshot;
        t_clear;
        t_min_mask;
        t_pause;
        t_reload;
        t_max_unimpl;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule